// File: doc/BRIEF.md
# Multicycle Register-File Processor

This block is a 16-bit processor that runs one instruction at a time with no overlap. A controller state machine drives named strobes into a datapath. The datapath holds a program counter, an instruction register, sixteen 16-bit general registers, one add/subtract unit with a zero flag, and a single port into a unified program/data memory. Every instruction takes the same route through the controller. FETCH presents the PC to memory. FETCH_WAIT captures the instruction and steps the PC. DECODE branches on the opcode to one execute state. Each execute state then returns to FETCH.

The memory array lives inside the block. It reads synchronously, so data appears one edge after the read strobe. While reset is held, a loader port owns the memory: the surrounding system writes a program and data words through it, and reads results back through it after a run. The execute states are:

- LOAD_DIR followed by LOAD_WAIT
- STORE_DIR
- STORE_IND
- LOAD_IMM
- ADD
- SUB
- JUMP_Z
- HALT

The transitions are as follows. Reset leads to FETCH. FETCH goes to FETCH_WAIT, and FETCH_WAIT goes to DECODE. DECODE goes to one execute state chosen by the opcode. LOAD_DIR goes to LOAD_WAIT. LOAD_WAIT and every other execute state except HALT go to FETCH. HALT stays in HALT.

Top module: `fsmd_cpu`

## Requirements
- R1: While reset is low, and right after it is released, `halted` is 0, the program counter is 0 and the controller is in FETCH, so the first instruction executed is the word at address 0.
- R2: Each instruction passes FETCH, FETCH_WAIT, DECODE and then one execute state, taking 4 clock cycles. A direct load takes 5 cycles, because LOAD_WAIT follows LOAD_DIR. The PC advances by exactly one in FETCH_WAIT.
- R3: The instruction fields are fixed. The opcode is bits 15..12. The first register `rn` is bits 11..8. The second register `rm` is bits 7..4. The 8-bit address, immediate or offset field is bits 7..0.
- R4: Opcode 0011 writes the 8-bit field, zero-extended to 16 bits, into `rn`.
- R5: Opcode 0000 loads `rn` from memory at the zero-extended 8-bit address.
- R6: Opcode 0001 writes `rn` to memory at the zero-extended 8-bit address.
- R7: Opcode 0010 writes `rm` to memory at the address held in `rn`.
- R8: Opcode 0100 sets `rn = rn + rm`, and opcode 0101 sets `rn = rn - rm`, both modulo 2^16.
- R9: Opcode 0110 tests `rn`. When `rn` is zero, the PC becomes the incremented PC plus the sign-extended 8-bit offset. Otherwise execution continues at the next word. The jump can go forwards or backwards.
- R10: Any opcode from 0111 to 1111 moves the controller to HALT. In HALT, `halted` is 1, no memory write occurs, and the state holds until reset.
- R11: Memory read data is registered and appears one edge after the read strobe. The core never asserts read and write in the same cycle.
- R12: The loader port writes memory only while `rst_n` is low. A loader write attempted while the core runs has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; while low, the loader port owns memory |
| halted | output | 1 | High while the controller sits in HALT |
| dbg_we | input | 1 | Loader write strobe, honoured only during reset |
| dbg_addr | input | 16 | Loader word address |
| dbg_wdata | input | 16 | Loader write data |
| dbg_rdata | output | 16 | Memory read data, registered, one edge after the address |

## Verification
The hardest case to reach from the ports is a jump-if-zero whose offset is negative. A wrong sign extension there sends the PC far away, and the only symptom is a missing or stray memory word. The test places a taken backward jump directly after a store, so that a correct jump lands on a halt word. A wrong target instead runs into a store over a preloaded sentinel. A second jump in the same program must not be taken; its not-taken path is checked through a stored marker. Register values are visible only after they are stored to memory, so every arithmetic and load result is written to memory and read back through the loader port once reset is reasserted.

// File: rtl/fsmd_pkg.sv
`timescale 1ns/1ps
package fsmd_pkg;

    localparam int DW = 16;
    localparam int FW = 8;

    localparam logic [3:0] OP_LD_DIR = 4'h0;
    localparam logic [3:0] OP_ST_DIR = 4'h1;
    localparam logic [3:0] OP_ST_IND = 4'h2;
    localparam logic [3:0] OP_LD_IMM = 4'h3;
    localparam logic [3:0] OP_ADD    = 4'h4;
    localparam logic [3:0] OP_SUB    = 4'h5;
    localparam logic [3:0] OP_JZ     = 4'h6;

    typedef enum logic [3:0] {
        S_FETCH, S_FWAIT, S_DECODE, S_LDDIR, S_LDWAIT, S_STDIR,
        S_STIND, S_LDIMM, S_ADD, S_SUB, S_JZ, S_HALT
    } state_t;

    typedef enum logic [1:0] { WSRC_ALU, WSRC_MEM, WSRC_IMM } wsrc_t;
    typedef enum logic [1:0] { ASRC_PC, ASRC_DIR, ASRC_RN } asrc_t;

    typedef struct packed {
        logic  ir_ld;
        logic  pc_inc;
        logic  pc_jmp;
        logic  rf_we;
        wsrc_t rf_src;
        logic  alu_sub;
        logic  alu_bzero;
        logic  mem_re;
        logic  mem_we;
        asrc_t addr_src;
        logic  wd_rm;
    } ctrl_t;

endpackage

// File: rtl/fsmd_alu.sv
`timescale 1ns/1ps
module fsmd_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        y    = sub ? (a - b) : (a + b);
        zero = (y == '0);
    end
endmodule

// File: rtl/fsmd_mem.sv
`timescale 1ns/1ps
module fsmd_mem #(
    parameter int W     = 16,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         re,
    input  logic         we,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    logic [W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[addr] <= wdata;
        if (re) rdata <= arr[addr];
    end
endmodule

// File: rtl/fsmd_ctrl.sv
`timescale 1ns/1ps
module fsmd_ctrl
    import fsmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic [3:0] opcode,
    output ctrl_t  ctl,
    output logic   halted
);
    state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:  state_d = S_FWAIT;
            S_FWAIT:  state_d = S_DECODE;
            S_DECODE: begin
                unique case (opcode)
                    OP_LD_DIR: state_d = S_LDDIR;
                    OP_ST_DIR: state_d = S_STDIR;
                    OP_ST_IND: state_d = S_STIND;
                    OP_LD_IMM: state_d = S_LDIMM;
                    OP_ADD:    state_d = S_ADD;
                    OP_SUB:    state_d = S_SUB;
                    OP_JZ:     state_d = S_JZ;
                    default:   state_d = S_HALT;
                endcase
            end
            S_LDDIR:  state_d = S_LDWAIT;
            S_HALT:   state_d = S_HALT;
            default:  state_d = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        ctl    = '0;
        halted = 1'b0;
        unique case (state_q)
            S_FETCH:  begin ctl.mem_re = 1'b1; ctl.addr_src = ASRC_PC; end
            S_FWAIT:  begin ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1; end
            S_DECODE: ;
            S_LDDIR:  begin ctl.mem_re = 1'b1; ctl.addr_src = ASRC_DIR; end
            S_LDWAIT: begin ctl.rf_we = 1'b1; ctl.rf_src = WSRC_MEM; end
            S_STDIR:  begin ctl.mem_we = 1'b1; ctl.addr_src = ASRC_DIR; end
            S_STIND:  begin ctl.mem_we = 1'b1; ctl.addr_src = ASRC_RN; ctl.wd_rm = 1'b1; end
            S_LDIMM:  begin ctl.rf_we = 1'b1; ctl.rf_src = WSRC_IMM; end
            S_ADD:    begin ctl.rf_we = 1'b1; ctl.rf_src = WSRC_ALU; end
            S_SUB:    begin ctl.rf_we = 1'b1; ctl.rf_src = WSRC_ALU; ctl.alu_sub = 1'b1; end
            S_JZ:     begin ctl.alu_bzero = 1'b1; ctl.pc_jmp = 1'b1; end
            S_HALT:   halted = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/fsmd_datapath.sv
`timescale 1ns/1ps
module fsmd_datapath
    import fsmd_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [3:0]    opcode,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    localparam int RW = $clog2(NREG);

    logic [DW-1:0] pc_q, ir_q;
    logic [DW-1:0] rf [NREG];
    logic [RW-1:0] rn, rm;
    logic [DW-1:0] field_zx, field_sx, alu_b, alu_y, wd;
    logic          zero;

    assign opcode   = ir_q[DW-1 -: 4];
    assign rn       = ir_q[8 +: RW];
    assign rm       = ir_q[4 +: RW];
    assign field_zx = {{(DW-FW){1'b0}}, ir_q[FW-1:0]};
    assign field_sx = {{(DW-FW){ir_q[FW-1]}}, ir_q[FW-1:0]};
    assign alu_b    = ctl.alu_bzero ? '0 : rf[rm];

    fsmd_alu #(.W(DW)) u_alu (
        .a(rf[rn]), .b(alu_b), .sub(ctl.alu_sub), .y(alu_y), .zero(zero)
    );

    always_comb begin
        unique case (ctl.rf_src)
            WSRC_MEM: wd = mem_rdata;
            WSRC_IMM: wd = field_zx;
            default:  wd = alu_y;
        endcase
        unique case (ctl.addr_src)
            ASRC_DIR: mem_addr = field_zx;
            ASRC_RN:  mem_addr = rf[rn];
            default:  mem_addr = pc_q;
        endcase
        mem_wdata = ctl.wd_rm ? rf[rm] : rf[rn];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (ctl.ir_ld) ir_q <= mem_rdata;
            if (ctl.pc_inc)              pc_q <= pc_q + 1'b1;
            else if (ctl.pc_jmp && zero) pc_q <= pc_q + field_sx;
        end
    end

    always_ff @(posedge clk) begin
        if (ctl.rf_we) rf[rn] <= wd;
    end
endmodule

// File: rtl/fsmd_cpu.sv
`timescale 1ns/1ps
module fsmd_cpu
    import fsmd_pkg::*;
#(
    parameter int MEM_DEPTH = 256,
    parameter int NREG      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          halted,
    input  logic          dbg_we,
    input  logic [DW-1:0] dbg_addr,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata
);
    ctrl_t         ctl;
    logic [3:0]    opcode;
    logic [DW-1:0] core_addr, core_wdata, mem_addr, mem_wdata, mem_rdata;
    logic          core_re, core_we, mem_re, mem_we;

    fsmd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ctl(ctl), .halted(halted)
    );

    fsmd_datapath #(.NREG(NREG)) u_dp (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
        .opcode(opcode), .mem_addr(core_addr), .mem_wdata(core_wdata)
    );

    assign core_re   = ctl.mem_re;
    assign core_we   = ctl.mem_we;
    assign mem_addr  = rst_n ? core_addr  : dbg_addr;
    assign mem_wdata = rst_n ? core_wdata : dbg_wdata;
    assign mem_we    = rst_n ? core_we    : dbg_we;
    assign mem_re    = rst_n ? core_re    : 1'b1;
    assign dbg_rdata = mem_rdata;

    fsmd_mem #(.W(DW), .DEPTH(MEM_DEPTH)) u_mem (
        .clk(clk), .re(mem_re), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );
endmodule

// File: rtl/fsmd_cpu_chk.sv
`timescale 1ns/1ps
module fsmd_cpu_chk
    import fsmd_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          halted,
    input state_t        state,
    input logic [DW-1:0] pc,
    input logic          mem_re,
    input logic          mem_we
);
    a_r11_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FWAIT) |=> (pc == $past(pc) + 16'd1));

    a_r2_decode_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE) |=> !(state inside {S_FETCH, S_FWAIT, S_DECODE}));

    a_r2_exec_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_LDWAIT, S_STDIR, S_STIND, S_LDIMM, S_ADD, S_SUB, S_JZ})
        |=> (state == S_FETCH));

    a_r5_load_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LDDIR) |=> (state == S_LDWAIT));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(pc)));
endmodule

bind fsmd_cpu fsmd_cpu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted), .state(u_ctrl.state_q),
    .pc(u_dp.pc_q), .mem_re(core_re), .mem_we(core_we)
);

// File: tb/fsmd_cpu_tb.sv
`timescale 1ns/1ps
module fsmd_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halted;
    logic        dbg_we = 1'b0;
    logic [15:0] dbg_addr = '0;
    logic [15:0] dbg_wdata = '0;
    logic [15:0] dbg_rdata;
    int          errors = 0;
    int          checks = 0;

    always #10 clk = ~clk;

    fsmd_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .halted(halted), .dbg_we(dbg_we),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        dbg_addr = a;
        @(negedge clk);
        d = dbg_rdata;
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic stop();
        @(negedge clk);
        rst_n = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 halted low in reset", {15'd0, halted}, 16'd0);
    endtask

    task automatic t_imm_store();
        int c; logic [15:0] v;
        poke(16'h0080, 16'h0000);
        poke(0, 16'h31AB); poke(1, 16'h1180); poke(2, 16'hF000);
        run(c);
        chk("R1 start at address 0, R2 cycle count", c[15:0], 16'd11);
        stop();
        peek(16'h0080, v);
        chk("R4/R6 immediate zero-extended and stored", v, 16'h00AB);
    endtask

    task automatic t_load_arith();
        int c; logic [15:0] v;
        poke(16'h0040, 16'h1234); poke(16'h0041, 16'h0FFF);
        poke(0, 16'h0240); poke(1, 16'h0341); poke(2, 16'h4230);
        poke(3, 16'h1281); poke(4, 16'h5320); poke(5, 16'h1382);
        poke(6, 16'hF000);
        run(c);
        chk("R2/R5 cycle count with load wait", c[15:0], 16'd29);
        stop();
        peek(16'h0081, v);
        chk("R3/R5/R8/R11 load then add", v, 16'h2233);
        peek(16'h0082, v);
        chk("R8 subtract wraps", v, 16'hEDCC);
    endtask

    task automatic t_indirect();
        int c; logic [15:0] v;
        poke(16'h0090, 16'h0000);
        poke(0, 16'h3490); poke(1, 16'h355A); poke(2, 16'h2450); poke(3, 16'hF000);
        run(c);
        stop();
        peek(16'h0090, v);
        chk("R7/R3 indirect store of rm at address in rn", v, 16'h005A);
    endtask

    task automatic t_jump();
        int c; logic [15:0] v;
        poke(16'h0083, 16'h0000); poke(16'h0084, 16'hDEAD);
        poke(0, 16'h3000); poke(1, 16'h3101); poke(2, 16'h6102);
        poke(3, 16'h3611); poke(4, 16'h6002); poke(5, 16'h3622);
        poke(6, 16'hF000); poke(7, 16'h1683); poke(8, 16'h60FD);
        poke(9, 16'h1684); poke(10, 16'hF000);
        run(c);
        stop();
        peek(16'h0083, v);
        chk("R9 not-taken then taken forward jump", v, 16'h0011);
        peek(16'h0084, v);
        chk("R9 backward jump skips sentinel store", v, 16'hDEAD);
    endtask

    task automatic t_halt();
        int c; logic [15:0] v;
        poke(16'h0085, 16'hBEEF);
        poke(0, 16'h3133); poke(1, 16'h7000); poke(2, 16'h1185); poke(3, 16'hF000);
        run(c);
        chk("R10 halted after opcode 0111", {15'd0, halted}, 16'd1);
        chk("R10 halt cycle count", c[15:0], 16'd7);
        repeat (20) @(negedge clk);
        chk("R10 halt holds", {15'd0, halted}, 16'd1);
        stop();
        peek(16'h0085, v);
        chk("R10 no store after halt", v, 16'hBEEF);
    endtask

    task automatic t_loader_ignored();
        int c; logic [15:0] v;
        poke(16'h0086, 16'h0000);
        poke(0, 16'h3201); poke(1, 16'h3302); poke(2, 16'h4230);
        poke(3, 16'h1287); poke(4, 16'hF000);
        @(negedge clk);
        rst_n = 1'b1;
        dbg_we = 1'b1; dbg_addr = 16'h0086; dbg_wdata = 16'h1111;
        repeat (4) @(negedge clk);
        dbg_we = 1'b0;
        c = 4;
        while (!halted && c < 2000) begin
            @(negedge clk);
            c++;
        end
        stop();
        peek(16'h0086, v);
        chk("R12 loader write ignored while running", v, 16'h0000);
        peek(16'h0087, v);
        chk("R12 program unaffected by loader", v, 16'h0003);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_imm_store();
        t_load_arith();
        t_indirect();
        t_jump();
        t_halt();
        t_loader_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule